// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is the bus-facing half of a small nonvolatile store of 512 bytes. The array is modelled here as on-chip registers. A host reaches it over a two-wire serial bus: a clock line and a bidirectional data line. Both lines are open-drain, so the data line is seen as an input plus an output enable that pulls it low. The block samples both lines with the system clock and finds start and stop conditions. It decodes a slave address byte, then a word address byte, then data. It supports single-byte and page writes, and current-address, random and sequential reads.

A write is not applied at once. Received bytes are held in a 16-entry page buffer. The stop condition that ends the write starts a timed internal write cycle, with its length set by a parameter. At the end of that cycle, only the bytes that were received are copied into the array. While the cycle runs, the block does not answer on the bus at all. A host finds out when the write has finished by sending its address again and again until it is acknowledged.

Top module: `twi_eeprom`

## Requirements
- R1: The slave address byte carries the 6-bit device identity `DEV_ID` in bits 7:2, array address bit 8 in bit 1, and read (1) or write (0) in bit 0. A byte with any other identity is not acknowledged, and the bus is then ignored until the next start.
- R2: Every accepted byte is acknowledged by holding the data line low (`sda_oe` = 1) during the ninth clock. In a write, the byte after the slave address sets pointer bits 7:0, and bit 1 of the slave address sets pointer bit 8.
- R3: Each data byte of a write goes to the current pointer. After each byte, only pointer bits 3:0 advance, and bits 8:4 stay fixed. A seventeenth or later byte wraps within the 16-byte page and replaces the byte written earlier at that spot.
- R4: A stop that follows at least one data byte starts an internal write cycle of `WR_CYCLES` clocks. The array changes only when that cycle ends, and only at the locations that received a byte.
- R5: During the internal write cycle the block acknowledges nothing, drives nothing, and ignores all bus traffic. A full write sent during the cycle changes nothing. Once the cycle is over, the address is acknowledged again.
- R6: A stop that follows only a word address, with no data byte, starts no write cycle. The pointer keeps the address that was sent.
- R7: Read data leaves most significant bit first. A 0 bit is sent as `sda_oe` = 1. A random read is a write of the word address, then a repeated start with a read address.
- R8: When the host acknowledges a read byte, the next byte follows. The full 9-bit pointer advances by one after every byte sent, and location 511 is followed by 0.
- R9: If the host leaves the data line high on the ninth clock of a read byte, or sends a stop there, the block releases the line and drives nothing until the next start.
- R10: A current-address read starts at the pointer left by the previous operation: the next page slot after the last byte written, or the location after the last byte read.
- R11: A repeated start restarts address decoding and keeps the pointer. Bytes staged before it are discarded and never written.
- R12: After reset, `sda_oe` is 0, the pointer is 0 and every array byte is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to sample both bus lines |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Level seen on the serial clock line |
| sda_i | input | 1 | Level seen on the serial data line |
| sda_oe | output | 1 | When 1, the data line is pulled low |

## Verification
The bench aims at page writes that start in the middle of a page and run past sixteen bytes. A design that carried the increment into bit 4 would spill into the next page rather than overwrite the start of its own. It polls right after each stop: a slave that answered during the write cycle, or that let a write sent during the cycle reach the array, would show up there. It also reads across location 511 and then does a current-address read, which catches a pointer that stops at the top or is not advanced past the last byte sent. Finally, it breaks off a write with a repeated start and then polls: a design that wrote the discarded bytes would go busy or change the stored data.

// File: rtl/twi_eeprom_pkg.sv
package twi_eeprom_pkg;
  localparam int ADDR_W = 9;
  localparam int PAGE_W = 4;

  typedef enum logic [2:0] {
    S_IDLE, S_DEV, S_WADDR, S_WDATA, S_ACK, S_RDATA, S_RACK
  } twi_state_t;

  // page write step: low bits wrap, page number is kept
  function automatic logic [ADDR_W-1:0] page_step(input logic [ADDR_W-1:0] a);
    page_step = {a[ADDR_W-1:PAGE_W], a[PAGE_W-1:0] + PAGE_W'(1)};
  endfunction

  // read step: whole pointer advances, top wraps to zero
  function automatic logic [ADDR_W-1:0] seq_step(input logic [ADDR_W-1:0] a);
    seq_step = a + ADDR_W'(1);
  endfunction
endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev,
  output logic sda_s
);
  logic [1:0] scl_m, sda_m;
  logic       scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_m <= 2'b11;
      sda_m <= 2'b11;
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_m <= {scl_m[0], scl_i};
      sda_m <= {sda_m[0], sda_i};
      scl_q <= scl_m[1];
      sda_q <= sda_m[1];
    end
  end

  assign sda_s    = sda_m[1];
  assign scl_rise = scl_m[1] & ~scl_q;
  assign scl_fall = ~scl_m[1] & scl_q;
  assign start_ev = scl_m[1] & scl_q & sda_q & ~sda_m[1];
  assign stop_ev  = scl_m[1] & scl_q & ~sda_q & sda_m[1];
endmodule

// File: rtl/twi_wr_timer.sv
module twi_wr_timer #(
  parameter int unsigned CYCLES = 500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  output logic busy,
  output logic commit
);
  localparam int CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (busy) begin
      if (cnt == LAST) begin
        busy <= 1'b0;
        cnt  <= '0;
      end else begin
        cnt <= cnt + CW'(1);
      end
    end else if (go) begin
      busy <= 1'b1;
      cnt  <= '0;
    end
  end

  assign commit = busy && (cnt == LAST);
endmodule

// File: rtl/twi_store.sv
module twi_store
  import twi_eeprom_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              stage_we,
  input  logic [7:0]        stage_data,
  input  logic              stage_clr,
  input  logic              commit,
  output logic [7:0]        rd_data,
  output logic              any_staged
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PAGE  = 1 << PAGE_W;

  logic [7:0]      mem  [DEPTH];
  logic [7:0]      pbuf [PAGE];
  logic [PAGE-1:0] pval;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
    end else if (commit) begin
      for (int i = 0; i < PAGE; i++)
        if (pval[i]) mem[{addr[ADDR_W-1:PAGE_W], PAGE_W'(i)}] <= pbuf[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pval <= '0;
    else if (commit || stage_clr) pval <= '0;
    else if (stage_we) pval[addr[PAGE_W-1:0]] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (stage_we) pbuf[addr[PAGE_W-1:0]] <= stage_data;
  end

  assign rd_data    = mem[addr];
  assign any_staged = |pval;

  // R4
  commit_has_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> any_staged);
endmodule

// File: rtl/twi_eeprom_ctrl.sv
module twi_eeprom_ctrl
  import twi_eeprom_pkg::*;
#(
  parameter logic [5:0] DEV_ID = 6'b101000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_ev,
  input  logic              stop_ev,
  input  logic              sda_s,
  input  logic              busy,
  input  logic [7:0]        rd_data,
  input  logic              any_staged,
  output logic [ADDR_W-1:0] ptr,
  output logic              stage_we,
  output logic [7:0]        stage_data,
  output logic              stage_clr,
  output logic              go,
  output logic              sda_oe
);
  twi_state_t st, after;
  logic [2:0] bitcnt;
  logic       full, ack_oe, blk, more;
  logic [7:0] sh, tx;

  logic dev_hit, byte_in, wr_byte_ev;
  assign dev_hit    = (sh[7:2] == DEV_ID);
  assign byte_in    = scl_fall && full &&
                      (st == S_DEV || st == S_WADDR || st == S_WDATA);
  assign wr_byte_ev = byte_in && (st == S_WDATA);
  assign stage_we   = wr_byte_ev;
  assign stage_data = sh;
  assign stage_clr  = start_ev && !busy;
  assign go         = stop_ev && !busy && any_staged;
  assign sda_oe     = ack_oe | ((st == S_RDATA) & ~tx[7]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; after <= S_IDLE; bitcnt <= '0; full <= 1'b0;
      sh <= '0; tx <= '0; ack_oe <= 1'b0; blk <= 1'b0; more <= 1'b0;
      ptr <= '0;
    end else if (busy || stop_ev) begin
      st     <= S_IDLE;
      ack_oe <= 1'b0;
    end else if (start_ev) begin
      st     <= S_DEV;
      bitcnt <= '0;
      full   <= 1'b0;
      ack_oe <= 1'b0;
    end else begin
      case (st)
        S_DEV, S_WADDR, S_WDATA: begin
          if (scl_rise && !full) begin
            sh <= {sh[6:0], sda_s};
            if (bitcnt == 3'd7) full <= 1'b1;
            else bitcnt <= bitcnt + 3'd1;
          end else if (byte_in) begin
            full   <= 1'b0;
            bitcnt <= '0;
            case (st)
              S_DEV: begin
                if (dev_hit) begin
                  ack_oe <= 1'b1;
                  st     <= S_ACK;
                  if (!sh[0]) blk <= sh[1];
                  after  <= sh[0] ? S_RDATA : S_WADDR;
                end else begin
                  st <= S_IDLE;
                end
              end
              S_WADDR: begin
                ptr    <= {blk, sh};
                ack_oe <= 1'b1;
                st     <= S_ACK;
                after  <= S_WDATA;
              end
              default: begin
                ptr    <= page_step(ptr);
                ack_oe <= 1'b1;
                st     <= S_ACK;
                after  <= S_WDATA;
              end
            endcase
          end
        end
        S_ACK: if (scl_fall) begin
          ack_oe <= 1'b0;
          st     <= after;
          if (after == S_RDATA) tx <= rd_data;
        end
        S_RDATA: if (scl_fall) begin
          if (bitcnt == 3'd7) begin
            st     <= S_RACK;
            bitcnt <= '0;
            ptr    <= seq_step(ptr);
          end else begin
            tx     <= {tx[6:0], 1'b0};
            bitcnt <= bitcnt + 3'd1;
          end
        end
        S_RACK: begin
          if (scl_rise) more <= ~sda_s;
          if (scl_fall) begin
            if (more) begin
              tx <= rd_data;
              st <= S_RDATA;
            end else begin
              st <= S_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  // R5
  busy_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sda_oe);
  // R4
  cycle_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop_ev));
  // R3
  page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_byte_ev |=> (ptr[ADDR_W-1:PAGE_W] == $past(ptr[ADDR_W-1:PAGE_W])));
  // R9
  release_after_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RACK) |-> !sda_oe);
endmodule

// File: rtl/twi_eeprom.sv
module twi_eeprom
  import twi_eeprom_pkg::*;
#(
  parameter logic [5:0]  DEV_ID    = 6'b101000,
  parameter int unsigned WR_CYCLES = 500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe
);
  logic scl_rise, scl_fall, start_ev, stop_ev, sda_s;
  logic busy, commit, go, stage_we, stage_clr, any_staged;
  logic [7:0] rd_data, stage_data;
  logic [ADDR_W-1:0] ptr;

  twi_line_sync u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev), .sda_s(sda_s)
  );

  twi_wr_timer #(.CYCLES(WR_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .go(go), .busy(busy), .commit(commit)
  );

  twi_store u_store (
    .clk(clk), .rst_n(rst_n), .addr(ptr),
    .stage_we(stage_we), .stage_data(stage_data), .stage_clr(stage_clr),
    .commit(commit), .rd_data(rd_data), .any_staged(any_staged)
  );

  twi_eeprom_ctrl #(.DEV_ID(DEV_ID)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev), .sda_s(sda_s), .busy(busy),
    .rd_data(rd_data), .any_staged(any_staged), .ptr(ptr),
    .stage_we(stage_we), .stage_data(stage_data), .stage_clr(stage_clr),
    .go(go), .sda_oe(sda_oe)
  );
endmodule

// File: tb/tb_twi_eeprom.sv
module tb_twi_eeprom;
  localparam int Q = 8;
  localparam int WRC = 1200;
  localparam logic [5:0] ID = 6'b101000;

  logic clk = 1'b0, rst_n = 1'b0, hscl = 1'b1, hsda = 1'b1;
  logic sda_oe, sda_bus;
  assign sda_bus = hsda & ~sda_oe;
  always #5 clk = ~clk;

  twi_eeprom #(.DEV_ID(ID), .WR_CYCLES(WRC)) dut (
    .clk(clk), .rst_n(rst_n), .scl_i(hscl), .sda_i(sda_bus), .sda_oe(sda_oe)
  );

  int errs = 0, checks = 0;
  logic [7:0] model [512];
  logic [8:0] mptr;
  logic [7:0] wb [32];

  function automatic logic [7:0] devb(input logic b, input logic rd);
    devb = {ID, b, rd};
  endfunction
  function automatic logic [8:0] in_page(input logic [8:0] a, input int k);
    in_page = {a[8:4], 4'(int'(a[3:0]) + k)};
  endfunction
  function automatic logic [8:0] lin(input logic [8:0] a, input int k);
    lin = 9'((int'(a) + k) % 512);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask
  task automatic hold(input int n); repeat (n) @(negedge clk); endtask

  task automatic clk_bit(input logic b, output logic s);
    hold(1); hsda = b; hold(Q - 1); hscl = 1'b1; hold(Q / 2); s = sda_bus; hold(Q / 2); hscl = 1'b0;
  endtask
  task automatic bus_start();
    hold(1); hsda = 1'b1; hold(Q); hscl = 1'b1; hold(Q); hsda = 1'b0; hold(Q); hscl = 1'b0;
  endtask
  task automatic bus_stop();
    hold(1); hsda = 1'b0; hold(Q); hscl = 1'b1; hold(Q); hsda = 1'b1; hold(Q);
  endtask
  task automatic put_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
    clk_bit(1'b1, s);
    ack = ~s;
  endtask
  task automatic get_byte(input logic mack, output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin clk_bit(1'b1, s); d[i] = s; end
    clk_bit(~mack, s);
  endtask

  task automatic poll(output int nacks);
    logic a;
    nacks = 0;
    for (int k = 0; k < 40; k++) begin
      bus_start(); put_byte(devb(1'b0, 1'b0), a); bus_stop();
      if (a) break;
      nacks++;
    end
  endtask

  task automatic wr(input logic [8:0] a, input int n, input bit do_poll);
    logic ack, allok;
    int nk;
    allok = 1'b1;
    bus_start();
    put_byte(devb(a[8], 1'b0), ack); allok &= ack;
    put_byte(a[7:0], ack); allok &= ack;
    for (int k = 0; k < n; k++) begin
      put_byte(wb[k], ack); allok &= ack;
      model[in_page(a, k)] = wb[k];
    end
    bus_stop();
    chk(allok == 1'b1, "R2 write bytes acknowledged", allok, 1);
    mptr = in_page(a, n);
    if (do_poll) begin
      poll(nk);
      chk(nk >= 1, "R5 no ack while write cycle runs", nk, 1);
    end
  endtask

  task automatic rd_check(input int n, input string req);
    logic [7:0] d;
    for (int i = 0; i < n; i++) begin
      get_byte(i < n - 1, d);
      chk(d == model[mptr], req, d, model[mptr]);
      mptr = lin(mptr, 1);
    end
    hold(Q);
    chk(sda_oe == 1'b0, "R9 released after host nack", sda_oe, 0);
    bus_stop();
  endtask

  task automatic rd_random(input logic [8:0] a, input int n, input string req);
    logic ack;
    bus_start(); put_byte(devb(a[8], 1'b0), ack); put_byte(a[7:0], ack);
    bus_start(); put_byte(devb(1'b0, 1'b1), ack);
    chk(ack == 1'b1, "R7 read address acknowledged", ack, 1);
    mptr = a;
    rd_check(n, req);
  endtask

  task automatic rd_current(input int n, input string req);
    logic ack;
    bus_start(); put_byte(devb(1'b0, 1'b1), ack);
    chk(ack == 1'b1, "R10 current read address acknowledged", ack, 1);
    rd_check(n, req);
  endtask

  initial begin
    hold(190000);
    errs++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic ack;
    logic [7:0] d;
    int nk, n;
    logic [8:0] a;
    void'($urandom(32'd4242));
    for (int i = 0; i < 512; i++) model[i] = 8'h00;
    mptr = '0;
    hold(5); rst_n = 1'b1; hold(5);
    // R12 reset state
    chk(sda_oe == 1'b0, "R12 sda_oe after reset", sda_oe, 0);
    rd_current(2, "R12 array zero from pointer zero");

    // R1 foreign identity ignored
    bus_start(); put_byte({6'b101100, 2'b00}, ack);
    chk(ack == 1'b0, "R1 foreign identity not acked", ack, 0);
    put_byte(8'h10, ack); put_byte(8'hEE, ack); bus_stop();
    poll(nk);
    chk(nk == 0, "R1 foreign write started no cycle", nk, 0);
    rd_random(9'h010, 1, "R1 foreign write left data");

    // R2 R7 byte write with block bit
    wb[0] = 8'hC3; wr(9'h1A5, 1, 1'b1);
    rd_random(9'h1A5, 1, "R2 byte write readback");
    rd_random(9'h0A5, 1, "R2 block bit selects half");

    // R3 page write from mid page wraps inside page
    for (int k = 0; k < 16; k++) wb[k] = 8'(8'h40 + k);
    wr(9'h0F3, 16, 1'b1);
    rd_random(9'h0F0, 16, "R3 mid-page wrap");
    rd_random(9'h100, 1, "R3 next page untouched");

    // R3 more than sixteen bytes overwrite
    for (int k = 0; k < 20; k++) wb[k] = 8'(8'h80 + 3 * k);
    wr(9'h120, 20, 1'b1);
    rd_random(9'h120, 16, "R3 overflow overwrites");

    // R4 only received bytes change; R10 pointer after write
    wb[0] = 8'h11; wb[1] = 8'h22; wb[2] = 8'h33;
    wr(9'h125, 3, 1'b1);
    rd_current(2, "R10 current read after write");
    rd_random(9'h120, 16, "R4 partial page commit");

    // R8 sequential read across top
    wb[0] = 8'hA1; wb[1] = 8'hB2;
    wr(9'h1FE, 2, 1'b1);
    rd_random(9'h1FD, 5, "R8 sequential wrap 511 to 0");
    rd_current(1, "R10 current read after read");

    // R6 address only write
    bus_start(); put_byte(devb(1'b0, 1'b0), ack); put_byte(8'hF5, ack); bus_stop();
    poll(nk);
    chk(nk == 0, "R6 address-only write no cycle", nk, 0);
    mptr = 9'h0F5;
    rd_current(1, "R6 pointer kept");

    // R5 traffic during write cycle ignored
    wb[0] = 8'h01; wb[1] = 8'h02; wb[2] = 8'h03; wb[3] = 8'h04;
    wr(9'h040, 4, 1'b0);
    bus_start(); put_byte(devb(1'b0, 1'b0), ack);
    chk(ack == 1'b0, "R5 address refused during cycle", ack, 0);
    put_byte(8'h41, ack); put_byte(8'h5A, ack); put_byte(8'h5A, ack); bus_stop();
    poll(nk);
    rd_random(9'h040, 4, "R5 write during cycle ignored");

    // R11 repeated start discards staged bytes and keeps pointer
    bus_start(); put_byte(devb(1'b0, 1'b0), ack); put_byte(8'h60, ack);
    put_byte(8'h99, ack); put_byte(8'h98, ack);
    bus_start(); put_byte(devb(1'b0, 1'b1), ack);
    chk(ack == 1'b1, "R11 address after repeated start", ack, 1);
    mptr = 9'h062;
    rd_check(1, "R11 pointer kept over repeated start");
    poll(nk);
    chk(nk == 0, "R11 no cycle for discarded bytes", nk, 0);
    rd_random(9'h060, 2, "R11 staged bytes not written");

    // random writes with page readback
    for (int it = 0; it < 7; it++) begin
      a = 9'($urandom % 512);
      n = 1 + int'($urandom % 20);
      for (int k = 0; k < n; k++) wb[k] = 8'($urandom);
      wr(a, n, 1'b1);
      rd_random({a[8:4], 4'h0}, 16, "R3 random page write");
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule